// File: doc/BRIEF.md
# Layered Pixel Priority Mixer with Shadow and Highlight

This block picks one displayed pixel per clock out of three layers: a sprite pixel, a foreground plane pixel (or the window pixel that stands in for it), and a background plane pixel. If every layer is transparent, it falls back to a background color value. Each layer pixel carries a priority flag, a palette and a color index, and index zero means transparent. When shadow/highlight mode is enabled, two sprite color values stop drawing and instead darken or brighten whatever lies underneath. Priority bits then also decide whether an ordinary pixel is dimmed.

Both plane pixels come from per-plane circular line buffers that a tile fetcher fills ahead of the beam. The mixer keeps a scan position that moves by one entry per accepted pixel and steps its group base by sixteen at the end of each sixteen-pixel group. Each plane is read at that position minus the plane's fine horizontal scroll. The result is a six-bit color index, a shade select and a debug source code, all registered one clock after the input pixel. Color conversion and tile fetching sit outside.

Top module: `layer_mixer`

## Requirements
- R1: A layer pixel is 7 bits: bit 6 priority, bits 5:4 palette, bits 3:0 index, and index 0 is transparent. The winner is the first opaque pixel in the order: priority sprite, priority foreground, priority background plane, sprite, foreground, background plane. The winner's bits 5:0 are output as the color.
- R2: When all three layer pixels are transparent, the color output equals bg_color and the debug source is 0.
- R3: With sh_enable low, out_shade is always 0 (normal), and the sprite colors 0x3F and 0x3E are drawn as ordinary colors.
- R4: With sh_enable high, a sprite whose bits 5:0 are 0x3F is a shadow operator (out_shade 1) and 0x3E is a highlight operator (out_shade 2), whatever its priority bit. The color underneath is the first of: priority foreground, priority background plane, foreground, background plane, bg_color.
- R5: With sh_enable high and no operator, the output is shadowed (out_shade 1) only when no opaque priority pixel wins and neither plane pixel has its priority bit set, even a transparent one. Otherwise out_shade is 0.
- R6: With sh_enable high, a winning low-priority sprite with index 14 (and not an operator) is shown at normal shade even where R5 would shadow it.
- R7: With window_on high, the foreground pixel is read at the scan position with no fine-scroll offset, and it reports debug source 2 instead of 1.
- R8: Each plane is read at entry (scan position - fine scroll) mod 32. The scan position starts at 0 after reset or line_start and advances by one per valid pixel, with the group base stepping by 16 every 16 pixels.
- R9: out_dbg bits 2:0 give the source (0 background, 1 foreground, 2 window, 3 background plane, 4 sprite). Bit 3 is the winning pixel's priority bit (0 for background), bit 4 is set when shadowed and bit 5 when highlighted.
- R10: Outputs appear one clock after the input pixel. out_valid follows in_valid with that latency, and cycles with in_valid low neither produce output nor advance the scan position.
- R11: After reset, out_valid, out_color, out_shade and out_dbg are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Returns the scan position to entry 0 |
| a_wr_en | input | 1 | Write strobe for the foreground line buffer |
| a_wr_idx | input | 5 | Foreground line buffer write entry |
| a_wr_pix | input | 7 | Foreground pixel to store |
| b_wr_en | input | 1 | Write strobe for the background plane line buffer |
| b_wr_idx | input | 5 | Background plane line buffer write entry |
| b_wr_pix | input | 7 | Background plane pixel to store |
| in_valid | input | 1 | A pixel is to be mixed this cycle |
| spr_pix | input | 7 | Sprite layer pixel |
| a_fine | input | 4 | Foreground fine horizontal scroll |
| b_fine | input | 4 | Background plane fine horizontal scroll |
| window_on | input | 1 | Window replaces the foreground plane |
| sh_enable | input | 1 | Shadow/highlight mode |
| bg_color | input | 6 | Background color index |
| out_valid | output | 1 | Output pixel valid |
| out_color | output | 6 | Winning color index |
| out_shade | output | 2 | 0 normal, 1 shadow, 2 highlight |
| out_dbg | output | 6 | Debug source and flags |

## Verification
Directed single pixels walk the priority ladder one rung at a time, so each one tells apart two adjacent entries of the order, and it is repeated in both modes. In shadow/highlight mode the pixels separate operator sprites from drawn ones, and transparent-but-priority plane pixels from truly low-priority ones, so the shade rule is checked against the transparency rule. Index-14 sprites are set beside index-13 ones. Back-to-back streams with unequal fine scroll on each plane, longer than the buffer, show whether the read offsets, the group wrap and the line_start restart land on the right entries. Idle gaps between pixels show that the position holds still while nothing is valid.

// File: rtl/layer_mixer_pkg.sv
package layer_mixer_pkg;

    // One layer pixel: priority, palette, index (index 0 = transparent)
    typedef struct packed {
        logic       prio;
        logic [1:0] pal;
        logic [3:0] idx;
    } layer_pix_t;

    typedef enum logic [1:0] {
        SHADE_NORMAL = 2'd0,
        SHADE_DARK   = 2'd1,
        SHADE_BRIGHT = 2'd2
    } shade_t;

    typedef enum logic [2:0] {
        SRC_BG  = 3'd0,
        SRC_FG  = 3'd1,
        SRC_WIN = 3'd2,
        SRC_BP  = 3'd3,
        SRC_SPR = 3'd4
    } src_t;

    typedef enum logic [1:0] {
        PICK_BG,
        PICK_SPR,
        PICK_FG,
        PICK_BP
    } pick_t;

    // Debug word, MSB first: bright flag, dark flag, priority, source
    typedef struct packed {
        logic bright;
        logic dark;
        logic prio;
        src_t src;
    } dbg_t;

    typedef struct packed {
        logic [5:0] color;
        shade_t     shade;
        dbg_t       dbg;
    } mix_out_t;

    localparam logic [5:0] OP_DARK_COLOR   = 6'h3F;
    localparam logic [5:0] OP_BRIGHT_COLOR = 6'h3E;
    localparam logic [3:0] KEEP_LIT_IDX    = 4'hE;

    function automatic logic opaque(input layer_pix_t p);
        return p.idx != 4'd0;
    endfunction

    function automatic logic urgent(input layer_pix_t p);
        return p.prio && (p.idx != 4'd0);
    endfunction

    function automatic logic [5:0] color_of(input layer_pix_t p);
        return {p.pal, p.idx};
    endfunction

endpackage

// File: rtl/mixer_linebuf.sv
module mixer_linebuf #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 7,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data
);
    // DEPTH is a power of two so index arithmetic wraps for free
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/mixer_scan.sv
module mixer_scan #(
    parameter int DEPTH  = 32,
    parameter int FINE_W = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int GROUP = 1 << FINE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              advance,
    input  logic [FINE_W-1:0] a_fine,
    input  logic [FINE_W-1:0] b_fine,
    input  logic              window_on,
    output logic [AW-1:0]     a_idx,
    output logic [AW-1:0]     b_idx
);
    logic [FINE_W-1:0] grp_pos;
    logic [AW-1:0]     grp_base;
    logic [AW-1:0]     cur;

    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            grp_pos  <= '0;
            grp_base <= '0;
        end else if (advance) begin
            grp_pos <= grp_pos + 1'b1;
            if (grp_pos == FINE_W'(GROUP - 1)) begin
                grp_base <= grp_base + AW'(GROUP);
            end
        end
    end

    assign cur   = grp_base + AW'(grp_pos);
    assign a_idx = window_on ? cur : cur - AW'(a_fine);
    assign b_idx = cur - AW'(b_fine);

endmodule

// File: rtl/mixer_resolve.sv
module mixer_resolve
    import layer_mixer_pkg::*;
(
    input  layer_pix_t spr,
    input  layer_pix_t fg,
    input  layer_pix_t bp,
    input  logic       window_on,
    input  logic       sh_enable,
    input  logic [5:0] bg_color,
    output mix_out_t   res
);
    pick_t  pick;
    shade_t shade;
    logic   op_hit;
    logic   dim;
    src_t   fg_src;

    assign fg_src = window_on ? SRC_WIN : SRC_FG;
    assign op_hit = sh_enable &&
                    (color_of(spr) == OP_DARK_COLOR || color_of(spr) == OP_BRIGHT_COLOR);

    // Winner selection and shade
    always_comb begin
        pick  = PICK_BG;
        shade = SHADE_NORMAL;
        dim   = 1'b0;
        if (op_hit) begin
            if (urgent(fg))       pick = PICK_FG;
            else if (urgent(bp))  pick = PICK_BP;
            else if (opaque(fg))  pick = PICK_FG;
            else if (opaque(bp))  pick = PICK_BP;
            shade = (color_of(spr) == OP_DARK_COLOR) ? SHADE_DARK : SHADE_BRIGHT;
        end else if (urgent(spr)) begin
            pick = PICK_SPR;
        end else if (urgent(fg)) begin
            pick = PICK_FG;
        end else if (urgent(bp)) begin
            pick = PICK_BP;
        end else begin
            dim = sh_enable && !fg.prio && !bp.prio;
            if (opaque(spr)) begin
                pick = PICK_SPR;
                if (spr.idx == KEEP_LIT_IDX) dim = 1'b0;
            end else if (opaque(fg)) begin
                pick = PICK_FG;
            end else if (opaque(bp)) begin
                pick = PICK_BP;
            end
            shade = dim ? SHADE_DARK : SHADE_NORMAL;
        end
    end

    // Map the winner to color and debug word
    always_comb begin
        res            = '0;
        res.shade      = shade;
        res.dbg.dark   = (shade == SHADE_DARK);
        res.dbg.bright = (shade == SHADE_BRIGHT);
        unique case (pick)
            PICK_SPR: begin
                res.color    = color_of(spr);
                res.dbg.prio = spr.prio;
                res.dbg.src  = SRC_SPR;
            end
            PICK_FG: begin
                res.color    = color_of(fg);
                res.dbg.prio = fg.prio;
                res.dbg.src  = fg_src;
            end
            PICK_BP: begin
                res.color    = color_of(bp);
                res.dbg.prio = bp.prio;
                res.dbg.src  = SRC_BP;
            end
            default: begin
                res.color    = bg_color;
                res.dbg.prio = 1'b0;
                res.dbg.src  = SRC_BG;
            end
        endcase
    end

endmodule

// File: rtl/layer_mixer.sv
module layer_mixer
    import layer_mixer_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int FINE_W    = 4,
    localparam int IDX_W    = $clog2(BUF_DEPTH),
    localparam int PIX_W    = $bits(layer_pix_t),
    localparam int PLANES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              a_wr_en,
    input  logic [IDX_W-1:0]  a_wr_idx,
    input  logic [PIX_W-1:0]  a_wr_pix,
    input  logic              b_wr_en,
    input  logic [IDX_W-1:0]  b_wr_idx,
    input  logic [PIX_W-1:0]  b_wr_pix,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  spr_pix,
    input  logic [FINE_W-1:0] a_fine,
    input  logic [FINE_W-1:0] b_fine,
    input  logic              window_on,
    input  logic              sh_enable,
    input  logic [5:0]        bg_color,
    output logic              out_valid,
    output logic [5:0]        out_color,
    output logic [1:0]        out_shade,
    output logic [5:0]        out_dbg
);
    logic [PLANES-1:0] wr_en_v;
    logic [IDX_W-1:0]  wr_idx_v [PLANES];
    logic [PIX_W-1:0]  wr_pix_v [PLANES];
    logic [IDX_W-1:0]  rd_idx_v [PLANES];
    logic [PIX_W-1:0]  rd_pix_v [PLANES];
    logic [PIX_W-1:0]  pix_a;
    logic [PIX_W-1:0]  pix_b;
    mix_out_t          nxt;
    mix_out_t          out_q;

    assign wr_en_v     = {b_wr_en, a_wr_en};
    assign wr_idx_v[0] = a_wr_idx;
    assign wr_idx_v[1] = b_wr_idx;
    assign wr_pix_v[0] = a_wr_pix;
    assign wr_pix_v[1] = b_wr_pix;

    mixer_scan #(.DEPTH(BUF_DEPTH), .FINE_W(FINE_W)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .advance    (in_valid),
        .a_fine     (a_fine),
        .b_fine     (b_fine),
        .window_on  (window_on),
        .a_idx      (rd_idx_v[0]),
        .b_idx      (rd_idx_v[1])
    );

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        mixer_linebuf #(.DEPTH(BUF_DEPTH), .WIDTH(PIX_W)) u_buf (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en_v[p]),
            .wr_idx  (wr_idx_v[p]),
            .wr_data (wr_pix_v[p]),
            .rd_idx  (rd_idx_v[p]),
            .rd_data (rd_pix_v[p])
        );
    end

    assign pix_a = rd_pix_v[0];
    assign pix_b = rd_pix_v[1];

    mixer_resolve u_resolve (
        .spr       (layer_pix_t'(spr_pix)),
        .fg        (layer_pix_t'(pix_a)),
        .bp        (layer_pix_t'(pix_b)),
        .window_on (window_on),
        .sh_enable (sh_enable),
        .bg_color  (bg_color),
        .res       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_q <= nxt;
            end
        end
    end

    assign out_color = out_q.color;
    assign out_shade = out_q.shade;
    assign out_dbg   = out_q.dbg;

endmodule

// File: rtl/layer_mixer_chk.sv
module layer_mixer_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [6:0] spr_pix,
    input logic       sh_enable,
    input logic [5:0] bg_color,
    input logic       a_on,
    input logic       a_prio,
    input logic       b_on,
    input logic       b_prio,
    input logic       out_valid,
    input logic [5:0] out_color,
    input logic [1:0] out_shade,
    input logic [5:0] out_dbg
);
    // R10: valid follows input valid one clock later
    a_r10_valid_latency: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // R2: all layers transparent gives the background color
    a_r2_bg_fallback: assert property (@(posedge clk) disable iff (rst)
        in_valid && spr_pix[3:0] == 4'd0 && !a_on && !b_on
        |=> out_color == $past(bg_color) && out_dbg[2:0] == 3'd0);

    // R3: no shading outside shadow/highlight mode
    a_r3_plain_shade: assert property (@(posedge clk) disable iff (rst)
        in_valid && !sh_enable |=> out_shade == 2'd0);

    // R4: operator sprites force shadow or highlight
    a_r4_dark_operator: assert property (@(posedge clk) disable iff (rst)
        in_valid && sh_enable && spr_pix[5:0] == 6'h3F |=> out_shade == 2'd1 && out_dbg[4]);

    a_r4_bright_operator: assert property (@(posedge clk) disable iff (rst)
        in_valid && sh_enable && spr_pix[5:0] == 6'h3E |=> out_shade == 2'd2 && out_dbg[5]);

    // R1: an opaque priority sprite (not an operator) wins
    a_r1_urgent_sprite: assert property (@(posedge clk) disable iff (rst)
        in_valid && spr_pix[6] && spr_pix[3:0] != 4'd0 &&
        !(sh_enable && spr_pix[5:1] == 5'h1F)
        |=> out_dbg[2:0] == 3'd4 && out_shade == 2'd0);

    // R6: index-14 sprite stays lit when it wins at low priority
    a_r6_keep_lit: assert property (@(posedge clk) disable iff (rst)
        in_valid && sh_enable && !spr_pix[6] && spr_pix[3:0] == 4'hE &&
        spr_pix[5:4] != 2'b11 && !(a_prio && a_on) && !(b_prio && b_on)
        |=> out_shade == 2'd0 && out_dbg[2:0] == 3'd4);

    // R9: debug word is self-consistent
    a_r9_dbg_legal: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_dbg[2:0] <= 3'd4 && !(out_dbg[5] && out_dbg[4]) &&
                      (out_dbg[3] -> out_dbg[2:0] != 3'd0));

endmodule

bind layer_mixer layer_mixer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .spr_pix   (spr_pix),
    .sh_enable (sh_enable),
    .bg_color  (bg_color),
    .a_on      (pix_a[3:0] != 4'd0),
    .a_prio    (pix_a[6]),
    .b_on      (pix_b[3:0] != 4'd0),
    .b_prio    (pix_b[6]),
    .out_valid (out_valid),
    .out_color (out_color),
    .out_shade (out_shade),
    .out_dbg   (out_dbg)
);

// File: tb/layer_mixer_tb.sv
module layer_mixer_tb;
    logic       clk = 1'b0;
    logic       rst, line_start;
    logic       a_wr_en, b_wr_en;
    logic [4:0] a_wr_idx, b_wr_idx;
    logic [6:0] a_wr_pix, b_wr_pix;
    logic       in_valid;
    logic [6:0] spr_pix;
    logic [3:0] a_fine, b_fine;
    logic       window_on, sh_enable;
    logic [5:0] bg_color;
    logic       out_valid;
    logic [5:0] out_color;
    logic [1:0] out_shade;
    logic [5:0] out_dbg;

    int n_chk = 0;
    int n_bad = 0;
    int pos   = 0;
    bit done  = 0;
    logic [6:0] ma [32];
    logic [6:0] mb [32];

    always #2 clk = ~clk;

    layer_mixer u_dut (
        .clk(clk), .rst(rst), .line_start(line_start),
        .a_wr_en(a_wr_en), .a_wr_idx(a_wr_idx), .a_wr_pix(a_wr_pix),
        .b_wr_en(b_wr_en), .b_wr_idx(b_wr_idx), .b_wr_pix(b_wr_pix),
        .in_valid(in_valid), .spr_pix(spr_pix), .a_fine(a_fine), .b_fine(b_fine),
        .window_on(window_on), .sh_enable(sh_enable), .bg_color(bg_color),
        .out_valid(out_valid), .out_color(out_color), .out_shade(out_shade),
        .out_dbg(out_dbg)
    );

    // Expected {valid, color, shade, dbg} from the requirements
    function automatic logic [14:0] model(input logic [6:0] s, a, b,
                                          input logic win, sh, input logic [5:0] bg);
        logic [5:0] col;
        logic [1:0] shd;
        logic       pr, dim;
        logic [2:0] src, asrc;
        logic       s_on, a_on, b_on;
        s_on = s[3:0] != 0;
        a_on = a[3:0] != 0;
        b_on = b[3:0] != 0;
        asrc = win ? 3'd2 : 3'd1;
        col = bg; pr = 1'b0; src = 3'd0; shd = 2'd0;
        if (sh && (s[5:0] == 6'h3F || s[5:0] == 6'h3E)) begin
            shd = s[0] ? 2'd1 : 2'd2;
            if (a[6] && a_on)      {col, pr, src} = {a[5:0], 1'b1, asrc};
            else if (b[6] && b_on) {col, pr, src} = {b[5:0], 1'b1, 3'd3};
            else if (a_on)         {col, pr, src} = {a[5:0], 1'b0, asrc};
            else if (b_on)         {col, pr, src} = {b[5:0], 1'b0, 3'd3};
        end else if (s[6] && s_on) {col, pr, src} = {s[5:0], 1'b1, 3'd4};
        else if (a[6] && a_on)     {col, pr, src} = {a[5:0], 1'b1, asrc};
        else if (b[6] && b_on)     {col, pr, src} = {b[5:0], 1'b1, 3'd3};
        else begin
            dim = sh && !a[6] && !b[6];
            if (s_on) begin
                {col, pr, src} = {s[5:0], 1'b0, 3'd4};
                if (s[3:0] == 4'hE) dim = 1'b0;
            end else if (a_on) {col, pr, src} = {a[5:0], 1'b0, asrc};
            else if (b_on)     {col, pr, src} = {b[5:0], 1'b0, 3'd3};
            shd = dim ? 2'd1 : 2'd0;
        end
        return {1'b1, col, shd, shd == 2'd2, shd == 2'd1, pr, src};
    endfunction

    task automatic chk(input string tag, input logic [14:0] got, input logic [14:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got v=%0b col=%h shade=%0d dbg=%h, expected v=%0b col=%h shade=%0d dbg=%h",
                     tag, got[14], got[13:8], got[7:6], got[5:0],
                     exp[14], exp[13:8], exp[7:6], exp[5:0]);
        end
    endtask

    function automatic logic [14:0] outs();
        return {out_valid, out_color, out_shade, out_dbg};
    endfunction

    task automatic quiet();
        a_wr_en = 0; b_wr_en = 0; in_valid = 0; line_start = 0;
    endtask

    // Load the two read entries, then mix one pixel and check it
    task automatic px(input string tag, input logic [6:0] s, a, b, input logic win, sh,
                      input logic [3:0] af, bf, input logic [5:0] bg);
        int ia, ib;
        logic [14:0] e;
        @(negedge clk);
        quiet();
        ia = (pos - (win ? 0 : int'(af))) & 31;
        ib = (pos - int'(bf)) & 31;
        a_wr_en = 1; a_wr_idx = 5'(ia); a_wr_pix = a; ma[ia] = a;
        b_wr_en = 1; b_wr_idx = 5'(ib); b_wr_pix = b; mb[ib] = b;
        @(negedge clk);
        quiet();
        in_valid = 1; spr_pix = s; a_fine = af; b_fine = bf;
        window_on = win; sh_enable = sh; bg_color = bg;
        e = model(s, ma[ia], mb[ib], win, sh, bg);
        pos++;
        @(negedge clk);
        quiet();
        chk(tag, outs(), e);
    endtask

    task automatic t_reset();
        chk("R11 reset state", outs(), 15'd0);
    endtask

    task automatic t_normal_order();
        px("R1 priority sprite over priority A", 7'h45, 7'h52, 7'h63, 0, 0, 0, 0, 6'h01);
        px("R1 priority A over plain sprite",    7'h05, 7'h52, 7'h63, 0, 0, 0, 0, 6'h01);
        px("R1 priority B over plain sprite",    7'h05, 7'h12, 7'h63, 0, 0, 0, 0, 6'h01);
        px("R1 plain sprite over plain A",       7'h05, 7'h12, 7'h23, 0, 0, 0, 0, 6'h01);
        px("R1 plain A under clear sprite",      7'h40, 7'h12, 7'h23, 0, 0, 0, 0, 6'h01);
        px("R1 B under clear sprite and A",      7'h00, 7'h50, 7'h23, 0, 0, 0, 0, 6'h01);
        px("R9 debug priority flag from B",      7'h30, 7'h20, 7'h7B, 0, 0, 0, 0, 6'h01);
        px("R2 background fallback",             7'h00, 7'h00, 7'h00, 0, 0, 0, 0, 6'h2A);
        px("R3 0x3F drawn in normal mode",       7'h3F, 7'h12, 7'h23, 0, 0, 0, 0, 6'h01);
        px("R3 0x3E drawn in normal mode",       7'h3E, 7'h12, 7'h23, 0, 0, 0, 0, 6'h01);
    endtask

    task automatic t_operators();
        px("R4 shadow op over priority B",    7'h3F, 7'h12, 7'h63, 0, 1, 0, 0, 6'h01);
        px("R4 highlight op over plain A",    7'h3E, 7'h12, 7'h23, 0, 1, 0, 0, 6'h01);
        px("R4 priority shadow op over bg",   7'h7F, 7'h00, 7'h00, 0, 1, 0, 0, 6'h15);
        px("R4 highlight op over priority A", 7'h3E, 7'h52, 7'h63, 0, 1, 0, 0, 6'h01);
        px("R4 shadow op over plain B",       7'h3F, 7'h40, 7'h23, 0, 1, 0, 0, 6'h01);
    endtask

    task automatic t_dim();
        px("R5 plain sprite shadowed",           7'h05, 7'h12, 7'h23, 0, 1, 0, 0, 6'h01);
        px("R5 plain A shadowed",                7'h00, 7'h12, 7'h23, 0, 1, 0, 0, 6'h01);
        px("R5 clear priority A blocks shadow",  7'h00, 7'h40, 7'h23, 0, 1, 0, 0, 6'h01);
        px("R5 priority sprite not shadowed",    7'h45, 7'h12, 7'h23, 0, 1, 0, 0, 6'h01);
        px("R5 background shadowed",             7'h00, 7'h00, 7'h00, 0, 1, 0, 0, 6'h33);
    endtask

    task automatic t_keep_lit();
        px("R6 index 14 sprite stays lit",     7'h0E, 7'h12, 7'h23, 0, 1, 0, 0, 6'h01);
        px("R6 index 14 palette 2 stays lit",  7'h2E, 7'h12, 7'h23, 0, 1, 0, 0, 6'h01);
        px("R6 index 13 sprite is shadowed",   7'h1D, 7'h12, 7'h23, 0, 1, 0, 0, 6'h01);
    endtask

    task automatic t_window();
        px("R7 window reads unscrolled",     7'h00, 7'h19, 7'h23, 1, 0, 4'd9, 4'd2, 6'h01);
        px("R7 window under shadow op",      7'h3F, 7'h5A, 7'h23, 1, 1, 4'd6, 4'd1, 6'h01);
        px("R8 fine scroll on both planes",  7'h00, 7'h00, 7'h27, 0, 0, 4'd3, 4'd7, 6'h01);
    endtask

    task automatic preload();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            quiet();
            ma[i] = 7'h20 | 7'(i);
            mb[i] = 7'(((i & 1) << 6) | 16 | ((31 - i) & 15));
            a_wr_en = 1; a_wr_idx = 5'(i); a_wr_pix = ma[i];
            b_wr_en = 1; b_wr_idx = 5'(i); b_wr_pix = mb[i];
        end
        @(negedge clk);
        quiet();
    endtask

    task automatic stream(input string tag, input int n, input logic [3:0] af, bf);
        logic [14:0] e;
        line_start = 1;
        @(negedge clk);
        quiet();
        pos = 0;
        for (int k = 0; k < n; k++) begin
            in_valid = 1; spr_pix = 7'h00; a_fine = af; b_fine = bf;
            window_on = 0; sh_enable = 0; bg_color = 6'h07;
            e = model(7'h00, ma[(pos - int'(af)) & 31], mb[(pos - int'(bf)) & 31], 0, 0, 6'h07);
            pos++;
            @(negedge clk);
            chk(tag, outs(), e);
        end
        quiet();
    endtask

    task automatic t_scroll();
        preload();
        stream("R8 stream fine A=5 B=11", 40, 4'd5, 4'd11);
        stream("R8 stream fine A=15 B=0", 36, 4'd15, 4'd0);
        @(negedge clk);
        line_start = 1;
        @(negedge clk);
        quiet();
        pos = 0;
        px("R8 line_start restarts position", 7'h00, 7'h1C, 7'h00, 0, 0, 4'd2, 4'd2, 6'h01);
    endtask

    task automatic t_gaps();
        px("R10 pixel before gap", 7'h00, 7'h13, 7'h00, 0, 0, 0, 0, 6'h01);
        repeat (3) begin
            @(negedge clk);
            quiet();
        end
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 idle cycles: got out_valid=%0b, expected 0", out_valid);
        end
        px("R10 position held across gap", 7'h00, 7'h14, 7'h00, 0, 0, 4'd1, 0, 6'h01);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            ma[i] = '0;
            mb[i] = '0;
        end
        rst = 1; quiet();
        a_wr_idx = 0; a_wr_pix = 0; b_wr_idx = 0; b_wr_pix = 0;
        spr_pix = 0; a_fine = 0; b_fine = 0; window_on = 0; sh_enable = 0; bg_color = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_normal_order();
        t_operators();
        t_dim();
        t_keep_lit();
        t_window();
        t_gaps();
        t_scroll();
        finish_run();
    end

endmodule